// File: doc/BRIEF.md
# Indirect Expansion Bus Access Port

This block gives a host a narrow register window onto an external parallel memory bus. The host loads a 16-bit lower address and a small upper address, picks one of two cycle flavours with a mode bit, and then touches a data-port register. That access is itself the trigger. A read of the data port runs one external read cycle and returns the captured value. A write of the data port stores the host value and runs one external write cycle with it.

In flash mode each cycle is byte-wide. The upper and lower address are joined into a 20-bit byte address. In SRAM mode each cycle moves a full 16-bit word, and only the lower address is driven, as a word address. An optional auto-increment advances the lower address after each completed data-port access, so software can stream through a region without reloading the address.

Configuration is protected. The mode and auto-increment bits change only while the stop input is high. The upper address and data-port writes are accepted while stop is high or while the SRAM size input is zero. The host side is a request/ready interface: ready drops for the whole external cycle.

Top module: `xbus_port`

## Requirements
- R1: Hard reset clears every register to zero, so the control register (select 1) reads 0000h. Select code 3 and control bits 13:4 are reserved: they read as zero and ignore writes.
- R2: The lower address register (select 0) can be written and read at any time, and returns the last value written to it.
- R3: The control register (select 1) holds flash mode in bit 15, auto-increment in bit 14 and the upper address in bits 3:0. Bits 15:14 change only when stop_i is high. Bits 3:0 change only when stop_i is high or sram_size_i is zero.
- R4: A data-port write (select 2) made while stop_i is low and sram_size_i is nonzero is ignored: ready is returned at once, no bus cycle runs, and neither the data register nor the lower address changes.
- R5: Each data-port read, and each accepted data-port write, runs exactly one bus cycle: one setup clock, then WAIT_CLKS strobe clocks. host_ready_o stays low from the request until the cycle ends, so the host sees WAIT_CLKS+2 stalled clocks.
- R6: A flash-mode read drives address {upper, lower} and returns the low data byte in bits 7:0, with bits 15:8 equal to zero.
- R7: A flash-mode write drives address {upper, lower} and places bits 7:0 of the written value on the data lines, with bits 15:8 driven as zero.
- R8: In SRAM mode, reads and writes drive the address as zero-extended lower address and transfer all 16 data bits.
- R9: With auto-increment set, the lower address rises by one after each completed data-port access. FFFFh wraps to 0000h, and the upper address does not change.
- R10: With auto-increment clear, data-port accesses leave the lower address unchanged.
- R11: During the strobe, chip-select is low, output-enable is low only for reads and write-enable is low only for writes. The two are never low together, and the address stays stable.
- R12: Changes on stop_i and sram_size_i with no host access leave the stored registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| stop_i | input | 1 | Stop condition that unlocks configuration writes |
| sram_size_i | input | 8 | Configured SRAM size; zero also unlocks upper address and data writes |
| host_req_i | input | 1 | Host access request, held until ready |
| host_we_i | input | 1 | Host access is a write |
| host_sel_i | input | 2 | Register select: 0 lower address, 1 control, 2 data port, 3 reserved |
| host_wdata_i | input | 16 | Host write data |
| host_ready_o | output | 1 | Access completes on the clock edge where request and ready are both high |
| host_rdata_o | output | 16 | Read data, valid while ready is high |
| mem_addr_o | output | 20 | External address |
| mem_dq_o | output | 16 | External write data |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | External read data |
| mem_cs_n_o | output | 1 | Chip-select, active low |
| mem_oe_n_o | output | 1 | Output-enable, active low |
| mem_we_n_o | output | 1 | Write-enable, active low |

## Verification
The bench walks the lower address up to FFFFh with auto-increment on and fires a flash read. This checks that the wrap lands on 0000h and leaves the upper address alone. A design that carried into the upper field, or that stepped before the cycle ended, would fetch from the wrong location. Locked writes to the control register and the data port are tried with stop low and a nonzero size. A design that ignored the gating would change mode, or would start a bus cycle that the cycle counter reports. Flash and SRAM cycles are mixed so that address phasing and byte handling are compared against a bench memory pattern. A block that leaked the high byte, or drove the upper address in SRAM mode, would return or emit values the bench does not expect.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DATA = 2'd2,
        SEL_RSVD = 2'd3
    } xbus_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_DONE   = 2'd3
    } xbus_phase_e;

    localparam int CTRL_MODE_BIT = 15;
    localparam int CTRL_AINC_BIT = 14;

endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
    import xbus_pkg::*;
#(
    parameter int LO_W   = 16,
    parameter int HI_W   = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stop,
    input  logic              open_wr,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              step,
    output logic              flash_mode,
    output logic              auto_inc,
    output logic [HI_W-1:0]   hi_addr,
    output logic [LO_W-1:0]   lo_addr,
    output logic [DATA_W-1:0] data_reg
);

    typedef struct packed {
        logic              mode;
        logic              ainc;
        logic [HI_W-1:0]   hi;
        logic [LO_W-1:0]   lo;
        logic [DATA_W-1:0] data;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_LO: cfg_d.lo = wr_data[LO_W-1:0];
                SEL_CTRL: begin
                    if (stop) begin
                        cfg_d.mode = wr_data[CTRL_MODE_BIT];
                        cfg_d.ainc = wr_data[CTRL_AINC_BIT];
                    end
                    if (open_wr) begin
                        cfg_d.hi = wr_data[HI_W-1:0];
                    end
                end
                SEL_DATA: begin
                    if (open_wr) begin
                        cfg_d.data = wr_data;
                    end
                end
                default: ;
            endcase
        end
        if (cap_en) begin
            cfg_d.data = cap_data;
        end
        if (step && cfg_q.ainc) begin
            cfg_d.lo = cfg_q.lo + LO_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign flash_mode = cfg_q.mode;
    assign auto_inc   = cfg_q.ainc;
    assign hi_addr    = cfg_q.hi;
    assign lo_addr    = cfg_q.lo;
    assign data_reg   = cfg_q.data;

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
    import xbus_pkg::*;
#(
    parameter int LO_W      = 16,
    parameter int HI_W      = 4,
    parameter int DATA_W    = 16,
    parameter int WAIT_CLKS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 start_wr,
    input  logic                 accept,
    input  logic                 flash_mode,
    input  logic [HI_W-1:0]      hi_addr,
    input  logic [LO_W-1:0]      lo_addr,
    input  logic [DATA_W-1:0]    wr_word,
    input  logic [DATA_W-1:0]    dq_in,
    output xbus_phase_e          phase,
    output logic                 cap_en,
    output logic [DATA_W-1:0]    cap_data,
    output logic [HI_W+LO_W-1:0] addr_out,
    output logic [DATA_W-1:0]    dq_out,
    output logic                 dq_oe,
    output logic                 cs_n,
    output logic                 oe_n,
    output logic                 we_n
);

    localparam int MEM_AW = HI_W + LO_W;
    localparam int BYTE_W = DATA_W / 2;
    localparam int CNT_W  = (WAIT_CLKS < 2) ? 1 : $clog2(WAIT_CLKS);

    typedef struct packed {
        xbus_phase_e      ph;
        logic [CNT_W-1:0] cnt;
        logic             wr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.ph)
            PH_IDLE: begin
                if (start) begin
                    seq_d.ph = PH_SETUP;
                    seq_d.wr = start_wr;
                end
            end
            PH_SETUP: begin
                seq_d.ph  = PH_STROBE;
                seq_d.cnt = CNT_W'(WAIT_CLKS - 1);
            end
            PH_STROBE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph = PH_DONE;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PH_DONE: begin
                if (accept) begin
                    seq_d.ph = PH_IDLE;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, cnt: '0, wr: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    logic in_strobe;
    logic active;

    always_comb begin
        in_strobe = (seq_q.ph == PH_STROBE);
        active    = in_strobe || (seq_q.ph == PH_SETUP);
        phase     = seq_q.ph;
        cap_en    = in_strobe && (seq_q.cnt == '0) && !seq_q.wr;
        cap_data  = flash_mode ? DATA_W'(dq_in[BYTE_W-1:0]) : dq_in;
        if (!active) begin
            addr_out = '0;
        end else if (flash_mode) begin
            addr_out = {hi_addr, lo_addr};
        end else begin
            addr_out = MEM_AW'(lo_addr);
        end
        dq_oe  = active && seq_q.wr;
        if (!dq_oe) begin
            dq_out = '0;
        end else if (flash_mode) begin
            dq_out = DATA_W'(wr_word[BYTE_W-1:0]);
        end else begin
            dq_out = wr_word;
        end
        cs_n = !in_strobe;
        oe_n = !(in_strobe && !seq_q.wr);
        we_n = !(in_strobe && seq_q.wr);
    end

endmodule

// File: rtl/xbus_port.sv
module xbus_port
    import xbus_pkg::*;
#(
    parameter int LO_W      = 16,
    parameter int HI_W      = 4,
    parameter int DATA_W    = 16,
    parameter int SIZE_W    = 8,
    parameter int WAIT_CLKS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stop_i,
    input  logic [SIZE_W-1:0]    sram_size_i,
    input  logic                 host_req_i,
    input  logic                 host_we_i,
    input  logic [1:0]           host_sel_i,
    input  logic [DATA_W-1:0]    host_wdata_i,
    output logic                 host_ready_o,
    output logic [DATA_W-1:0]    host_rdata_o,
    output logic [HI_W+LO_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0]    mem_dq_o,
    output logic                 mem_dq_oe_o,
    input  logic [DATA_W-1:0]    mem_dq_i,
    output logic                 mem_cs_n_o,
    output logic                 mem_oe_n_o,
    output logic                 mem_we_n_o
);

    localparam int RSVD_W = DATA_W - 2 - HI_W;

    xbus_phase_e       phase;
    logic              flash_mode;
    logic              auto_inc;
    logic [HI_W-1:0]   hi_addr;
    logic [LO_W-1:0]   lo_addr;
    logic [DATA_W-1:0] data_reg;
    logic              cap_en;
    logic [DATA_W-1:0] cap_data;

    logic idle;
    logic open_wr;
    logic launch;
    logic reg_wr;
    logic step;

    always_comb begin
        idle    = (phase == PH_IDLE);
        open_wr = stop_i || (sram_size_i == '0);
        launch  = host_req_i && idle && (host_sel_i == SEL_DATA)
                  && (!host_we_i || open_wr);
        reg_wr  = host_req_i && host_we_i && idle;
        step    = host_req_i && (phase == PH_DONE);
        host_ready_o = (idle && !launch) || (phase == PH_DONE);
        case (host_sel_i)
            SEL_LO:   host_rdata_o = DATA_W'(lo_addr);
            SEL_CTRL: host_rdata_o = {flash_mode, auto_inc, {RSVD_W{1'b0}}, hi_addr};
            SEL_DATA: host_rdata_o = data_reg;
            default:  host_rdata_o = '0;
        endcase
    end

    xbus_cfg_regs #(
        .LO_W  (LO_W),
        .HI_W  (HI_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_sel    (host_sel_i),
        .wr_data   (host_wdata_i),
        .stop      (stop_i),
        .open_wr   (open_wr),
        .cap_en    (cap_en),
        .cap_data  (cap_data),
        .step      (step),
        .flash_mode(flash_mode),
        .auto_inc  (auto_inc),
        .hi_addr   (hi_addr),
        .lo_addr   (lo_addr),
        .data_reg  (data_reg)
    );

    xbus_cycle_seq #(
        .LO_W     (LO_W),
        .HI_W     (HI_W),
        .DATA_W   (DATA_W),
        .WAIT_CLKS(WAIT_CLKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (launch),
        .start_wr  (host_we_i),
        .accept    (host_req_i),
        .flash_mode(flash_mode),
        .hi_addr   (hi_addr),
        .lo_addr   (lo_addr),
        .wr_word   (data_reg),
        .dq_in     (mem_dq_i),
        .phase     (phase),
        .cap_en    (cap_en),
        .cap_data  (cap_data),
        .addr_out  (mem_addr_o),
        .dq_out    (mem_dq_o),
        .dq_oe     (mem_dq_oe_o),
        .cs_n      (mem_cs_n_o),
        .oe_n      (mem_oe_n_o),
        .we_n      (mem_we_n_o)
    );

endmodule

// File: rtl/xbus_port_chk.sv
module xbus_port_chk
    import xbus_pkg::*;
#(
    parameter int LO_W      = 16,
    parameter int HI_W      = 4,
    parameter int DATA_W    = 16,
    parameter int WAIT_CLKS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 stop_i,
    input logic                 host_req_i,
    input logic                 host_we_i,
    input logic [1:0]           host_sel_i,
    input logic                 host_ready_o,
    input logic [HI_W+LO_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0]    mem_dq_o,
    input logic                 mem_cs_n_o,
    input logic                 mem_oe_n_o,
    input logic                 mem_we_n_o,
    input logic                 flash_mode,
    input logic                 auto_inc,
    input logic [LO_W-1:0]      lo_addr
);

    localparam int BYTE_W = DATA_W / 2;

    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!mem_cs_n_o) begin
            low_cnt <= low_cnt + 16'd1;
        end else begin
            low_cnt <= '0;
        end
    end

    logic ctrl_wr_acc;
    logic lo_wr_acc;
    assign ctrl_wr_acc = host_req_i && host_we_i && host_ready_o && (host_sel_i == SEL_CTRL);
    assign lo_wr_acc   = host_req_i && host_we_i && host_ready_o && (host_sel_i == SEL_LO);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n_o && !mem_we_n_o)); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n_o |-> !host_ready_o); // R5

    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n_o) |-> (low_cnt == 16'(WAIT_CLKS))); // R5

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && !$past(mem_cs_n_o)) |-> $stable(mem_addr_o)); // R11

    AST_FLASH_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n_o && flash_mode) |-> (mem_dq_o[DATA_W-1:BYTE_W] == '0)); // R7

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_acc && !stop_i) |=> ($stable(flash_mode) && $stable(auto_inc))); // R3

    AST_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_inc && !lo_wr_acc) |=> $stable(lo_addr)); // R10

endmodule

bind xbus_port xbus_port_chk #(
    .LO_W     (LO_W),
    .HI_W     (HI_W),
    .DATA_W   (DATA_W),
    .WAIT_CLKS(WAIT_CLKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .host_req_i  (host_req_i),
    .host_we_i   (host_we_i),
    .host_sel_i  (host_sel_i),
    .host_ready_o(host_ready_o),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .mem_cs_n_o  (mem_cs_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .flash_mode  (flash_mode),
    .auto_inc    (auto_inc),
    .lo_addr     (lo_addr)
);

// File: tb/xbus_port_bench.sv
module xbus_port_bench;

    localparam int WAIT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop_i = 1'b0;
    logic [7:0]  sram_size_i = 8'd0;
    logic        host_req_i = 1'b0;
    logic        host_we_i = 1'b0;
    logic [1:0]  host_sel_i = 2'd0;
    logic [15:0] host_wdata_i = '0;
    logic        host_ready_o;
    logic [15:0] host_rdata_o;
    logic [19:0] mem_addr_o;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe_o;
    logic [15:0] mem_dq_i;
    logic        mem_cs_n_o;
    logic        mem_oe_n_o;
    logic        mem_we_n_o;

    always #4 clk = ~clk;

    xbus_port #(.WAIT_CLKS(WAIT)) u_xbus_port (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .sram_size_i(sram_size_i),
        .host_req_i(host_req_i), .host_we_i(host_we_i), .host_sel_i(host_sel_i),
        .host_wdata_i(host_wdata_i), .host_ready_o(host_ready_o),
        .host_rdata_o(host_rdata_o), .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o),
        .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i), .mem_cs_n_o(mem_cs_n_o),
        .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o)
    );

    function automatic logic [15:0] pat(input logic [19:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[19:16], a[19:16], 8'h00};
    endfunction

    assign mem_dq_i = pat(mem_addr_o);

    // bus monitor
    int          cyc_cnt = 0;
    int          both_low = 0;
    logic        prev_cs = 1'b1;
    logic [19:0] mon_addr = '0;
    logic [15:0] mon_wdata = '0;
    logic        mon_rd = 1'b0;
    logic        mon_wr = 1'b0;

    always @(negedge clk) begin
        if (!mem_cs_n_o) begin
            if (prev_cs) begin
                cyc_cnt++;
                mon_rd = 1'b0;
                mon_wr = 1'b0;
            end
            mon_addr = mem_addr_o;
            if (!mem_oe_n_o) mon_rd = 1'b1;
            if (!mem_we_n_o) begin
                mon_wr = 1'b1;
                mon_wdata = mem_dq_o;
            end
            if (!mem_oe_n_o && !mem_we_n_o) both_low++;
        end
        prev_cs = mem_cs_n_o;
    end

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [15:0] last_rd;
    int          last_n;

    task automatic acc(input logic [1:0] sel, input bit we, input logic [15:0] wd);
        @(negedge clk);
        host_req_i = 1'b1; host_sel_i = sel; host_we_i = we; host_wdata_i = wd;
        #1;
        last_n = 0;
        while (!host_ready_o) begin
            @(negedge clk);
            #1;
            last_n++;
        end
        last_rd = host_rdata_o;
        @(negedge clk);
        host_req_i = 1'b0;
    endtask

    // reference model
    logic        m_mode = 0, m_ainc = 0;
    logic [3:0]  m_hi = '0;
    logic [15:0] m_lo = '0, m_data = '0;

    task automatic do_op(input logic [1:0] sel, input bit we, input logic [15:0] wd);
        bit open_wr;
        bit launched;
        int cyc0;
        logic [19:0] ea;
        logic [15:0] ev;
        open_wr = stop_i || (sram_size_i == 8'd0);
        launched = (sel == 2'd2) && (!we || open_wr);
        cyc0 = cyc_cnt;
        ea = m_mode ? {m_hi, m_lo} : {4'h0, m_lo};
        acc(sel, we, wd);
        case (sel)
            2'd0: if (we) m_lo = wd;
                  else chk(last_rd == m_lo, "R2 lower address readback", last_rd, m_lo);
            2'd1: if (we) begin
                      if (stop_i) begin m_mode = wd[15]; m_ainc = wd[14]; end
                      if (open_wr) m_hi = wd[3:0];
                  end else begin
                      ev = {m_mode, m_ainc, 10'b0, m_hi};
                      chk(last_rd == ev, "R3 control readback", last_rd, ev);
                  end
            2'd2: if (launched) begin
                      chk(last_n == WAIT + 2, "R5 stall length", last_n, WAIT + 2);
                      chk(cyc_cnt == cyc0 + 1, "R5 one bus cycle", cyc_cnt, cyc0 + 1);
                      chk(mon_addr == ea, m_mode ? "R6 flash address" : "R8 sram address", mon_addr, ea);
                      chk(mon_wr == we && mon_rd == !we, "R11 strobe kind", {mon_rd, mon_wr}, {!we, we});
                      if (we) begin
                          m_data = wd;
                          ev = m_mode ? {8'h00, wd[7:0]} : wd;
                          chk(mon_wdata == ev, m_mode ? "R7 flash write data" : "R8 sram write data", mon_wdata, ev);
                      end else begin
                          m_data = m_mode ? {8'h00, pat(ea)[7:0]} : pat(ea);
                          chk(last_rd == m_data, m_mode ? "R6 flash read data" : "R8 sram read data", last_rd, m_data);
                      end
                      if (m_ainc) m_lo = m_lo + 16'd1;
                  end else begin
                      chk(last_n == 0 && cyc_cnt == cyc0, "R4 locked data write ignored", cyc_cnt, cyc0);
                  end
            default: if (!we) chk(last_rd == 16'h0, "R1 reserved select reads zero", last_rd, 0);
        endcase
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        acc(2'd1, 0, 0); chk(last_rd == 16'h0, "R1 control after reset", last_rd, 0);
        acc(2'd0, 0, 0); chk(last_rd == 16'h0, "R1 lower after reset", last_rd, 0);
        do_op(2'd3, 1, 16'hFFFF);
        do_op(2'd3, 0, 0);

        // R9 wrap with flash read
        stop_i = 1; sram_size_i = 8'd5;
        do_op(2'd0, 1, 16'hFFFF);
        do_op(2'd1, 1, 16'hFFFA);      // R1 reserved bits dropped
        do_op(2'd1, 0, 0);
        do_op(2'd2, 0, 0);
        acc(2'd0, 0, 0); chk(last_rd == 16'h0000, "R9 lower wraps to zero", last_rd, 0);
        acc(2'd1, 0, 0); chk(last_rd[3:0] == 4'hA, "R9 upper unchanged on wrap", last_rd, 16'hC00A);
        do_op(2'd2, 1, 16'h12F0);      // R7
        // R8 SRAM, R10 no increment
        do_op(2'd1, 1, 16'h000A);
        do_op(2'd2, 1, 16'hBEEF);
        do_op(2'd2, 0, 0);
        acc(2'd0, 0, 0); chk(last_rd == 16'h0001, "R10 lower held without auto-increment", last_rd, 1);
        // R3 / R4 locked
        stop_i = 0;
        do_op(2'd1, 1, 16'hC005);
        do_op(2'd1, 0, 0);
        do_op(2'd2, 1, 16'h7777);
        sram_size_i = 8'd0;
        do_op(2'd1, 1, 16'hC003);
        do_op(2'd1, 0, 0);
        do_op(2'd2, 1, 16'h7777);
        // R12 input toggling alone
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); stop_i = i[0]; sram_size_i = 8'(i * 7);
        end
        acc(2'd0, 0, 0); chk(last_rd == m_lo, "R12 lower kept across input changes", last_rd, m_lo);
        acc(2'd1, 0, 0);
        chk(last_rd == {m_mode, m_ainc, 10'b0, m_hi}, "R12 control kept across input changes",
            last_rd, {m_mode, m_ainc, 10'b0, m_hi});

        // constrained random
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            stop_i = ($urandom % 3) != 0;
            sram_size_i = (($urandom % 3) == 0) ? 8'd0 : 8'(($urandom % 255) + 1);
            if (($urandom % 20) == 0)
                do_op(2'd0, 1, 16'hFFFE + 16'($urandom % 2));
            else
                do_op(2'($urandom % 4), $urandom % 2, 16'($urandom));
        end
        chk(both_low == 0, "R11 strobes never both low", both_low, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule